// File: doc/BRIEF.md
# AIS Defect Integrator with Change-of-State Interrupt

This block sits behind a DS3 receive framer. The framer sends one strobe at the end of every received frame, along with a flag that says whether that frame carried the alarm indication signal (AIS) pattern. The block integrates these per-frame results into an AIS defect state, using a frame-count hysteresis in both directions. This keeps one stray frame from toggling the alarm.

Each time the defect is declared or cleared, the block can raise a change-of-state interrupt. The interrupt can be masked. A small processor register interface provides three things:

- an interrupt-enable register;
- an interrupt-status register that clears when read;
- a read-only register that shows the live defect state, so software can tell a declare from a clear.

An active-low interrupt request output reports any pending enabled event. Only the AIS position of the shared eight-source status layout is implemented. The other seven positions read as zero.

Top module: `ais_defect_monitor`

## Requirements
- R1: The defect is declared (goes to 1) on the frame strobe that completes 63 consecutive frames with `frame_ais`=1 while the defect is 0. 62 such frames leave it at 0.
- R2: The defect is cleared (goes to 0) on the frame strobe that completes 63 consecutive frames with `frame_ais`=0 while the defect is 1. 62 such frames leave it at 1.
- R3: A frame whose flag matches the current defect state restarts the count toward a change. Cycles without `frame_end` change nothing.
- R4: The enable register is at address 0x12. Bit 5 is the AIS enable: writing 1 enables and 0 disables. Every other bit reads as 0.
- R5: When the defect changes while bit 5 of 0x12 is 1, bit 5 of the status register at 0x13 is set in that same clock edge and `irq_n` goes low. This happens for both declare and clear.
- R6: A defect change while the enable is 0 sets no status bit. Setting the enable later does not assert `irq_n`.
- R7: A read of 0x13 returns the current status (AIS at bit 5, all other bits 0) and then clears it. `irq_n` returns high once no enabled status bit remains.
- R8: If a status set and a clearing read of 0x13 fall in the same cycle, the set wins. The read returns the old value, and the bit stays 1.
- R9: The live defect state reads as bit 7 of address 0x10. The other bits read 0, and writes to 0x10 have no effect.
- R10: A synchronous active-high `rst` clears the count, the defect, the status and the enable. After reset, `irq_n` is 1 and all three registers read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_end | input | 1 | One-cycle strobe at the end of each received frame |
| frame_ais | input | 1 | The frame just ended carried the AIS pattern (valid with frame_end) |
| cpu_addr | input | 8 | Register address |
| cpu_wr | input | 1 | Register write strobe |
| cpu_wdata | input | 8 | Register write data |
| cpu_rd | input | 1 | Register read strobe (clears status when addressing 0x13) |
| cpu_rdata | output | 8 | Read data for cpu_addr, combinational |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
Two functions can fall in the same cycle:

- the frame strobe that completes the 63rd qualifying frame, which sets the status bit;
- a processor read of the status register, which clears it.

The bench provokes this collision deliberately. It sends 62 AIS frames, then drives the 63rd strobe and a read of 0x13 on the same clock. The read must return 0, because the set is not yet visible. `irq_n` must then be low, and a following read must return 0x20. This shows that the set won over the clear.

// File: rtl/ais_defect_monitor.sv
module ais_defect_monitor #(
  parameter int          HYST_FRAMES = 63,
  parameter int          ADDR_W      = 8,
  parameter int          DATA_W      = 8,
  parameter logic [7:0]  STATE_ADDR  = 8'h10,
  parameter logic [7:0]  EN_ADDR     = 8'h12,
  parameter logic [7:0]  STAT_ADDR   = 8'h13,
  parameter int          AIS_BIT     = 5,
  parameter int          STATE_BIT   = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_end,
  input  logic              frame_ais,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_wr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              cpu_rd,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              irq_n
);

  localparam int CNT_W = $clog2(HYST_FRAMES + 1);
  localparam logic [CNT_W-1:0] LAST  = CNT_W'(HYST_FRAMES - 1);
  localparam logic [CNT_W-1:0] CMAX  = {CNT_W{1'b1}};

  logic [CNT_W-1:0] run_cnt;
  logic             defect;
  logic             en_ais;
  logic             stat_ais;

  wire opposite = frame_ais != defect;
  wire flip     = frame_end && opposite && (run_cnt == LAST);
  wire stat_set = flip && en_ais;
  wire stat_clr = cpu_rd && (cpu_addr == ADDR_W'(STAT_ADDR));
  wire en_wr    = cpu_wr && (cpu_addr == ADDR_W'(EN_ADDR));

  always_ff @(posedge clk) begin
    if (rst) begin
      run_cnt <= '0;
      defect  <= 1'b0;
    end else if (frame_end) begin
      if (!opposite || flip) run_cnt <= '0;
      else if (run_cnt != CMAX) run_cnt <= run_cnt + 1'b1;
      if (flip) defect <= ~defect;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) en_ais <= 1'b0;
    else if (en_wr) en_ais <= cpu_wdata[AIS_BIT];
  end

  always_ff @(posedge clk) begin
    if (rst) stat_ais <= 1'b0;
    else if (stat_set) stat_ais <= 1'b1;
    else if (stat_clr) stat_ais <= 1'b0;
  end

  always_comb begin
    cpu_rdata = '0;
    if (cpu_addr == ADDR_W'(EN_ADDR))         cpu_rdata[AIS_BIT]   = en_ais;
    else if (cpu_addr == ADDR_W'(STAT_ADDR))  cpu_rdata[AIS_BIT]   = stat_ais;
    else if (cpu_addr == ADDR_W'(STATE_ADDR)) cpu_rdata[STATE_BIT] = defect;
  end

  assign irq_n = ~(stat_ais & en_ais);

  // R1
  declare_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(defect) |-> $past(frame_end && frame_ais));

  // R2
  clear_src_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(defect) |-> $past(frame_end && !frame_ais));

  // R3
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    run_cnt < CNT_W'(HYST_FRAMES));

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !frame_end |=> $stable(defect));

  // R5
  stat_on_change_chk: assert property (@(posedge clk) disable iff (rst)
    (defect != $past(defect)) && $past(en_ais) |-> stat_ais);

  // R6
  stat_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(stat_ais) |-> (defect != $past(defect)) && $past(en_ais));

  // R7
  read_clear_chk: assert property (@(posedge clk) disable iff (rst)
    stat_clr && !flip |=> !stat_ais);

  // R8
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    stat_clr && stat_set |=> stat_ais && !irq_n);

endmodule

// File: tb/sim_ais_defect_monitor.sv
module sim_ais_defect_monitor;
  localparam int PERIOD = 10;
  localparam int VEC_N  = 8;
  localparam int      V_CNT [VEC_N] = '{62, 1, 62, 1, 62, 1, 63, 10};
  localparam bit      V_AIS [VEC_N] = '{1,  0, 1,  1, 0,  1, 0,  0};
  localparam bit      V_DEF [VEC_N] = '{0,  0, 0,  1, 1,  1, 0,  0};

  logic clk = 0, rst = 1, frame_end = 0, frame_ais = 0, cpu_wr = 0, cpu_rd = 0;
  logic [7:0] cpu_addr = 0, cpu_wdata = 0;
  logic [7:0] cpu_rdata;
  logic irq_n;
  int checks = 0, errors = 0;
  logic [7:0] rv;

  ais_defect_monitor u0 (
    .clk(clk), .rst(rst), .frame_end(frame_end), .frame_ais(frame_ais),
    .cpu_addr(cpu_addr), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
    .cpu_rd(cpu_rd), .cpu_rdata(cpu_rdata), .irq_n(irq_n));

  always #(PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_frames(input int n, input bit ais);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); frame_end = 1; frame_ais = ais;
      @(negedge clk); frame_end = 0;
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); cpu_addr = a; cpu_rd = 1;
    #1 d = cpu_rdata;
    @(negedge clk); cpu_rd = 0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); cpu_addr = a; cpu_wdata = d; cpu_wr = 1;
    @(negedge clk); cpu_wr = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
  endtask

  initial begin
    #(PERIOD * 200000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    do_reset();
    // R10 reset state
    check("R10 irq_n", {7'b0, irq_n}, 8'h01);
    rd(8'h12, rv); check("R10 enable", rv, 8'h00);
    rd(8'h13, rv); check("R10 status", rv, 8'h00);
    rd(8'h10, rv); check("R10 state", rv, 8'h00);

    // R1 R2 R3 table walk, enable off
    for (int v = 0; v < VEC_N; v++) begin
      send_frames(V_CNT[v], V_AIS[v]);
      repeat (3) @(negedge clk);
      rd(8'h10, rv);
      check(V_DEF[v] ? "R1/R3 state" : "R2/R3 state", rv, V_DEF[v] ? 8'h80 : 8'h00);
    end
    // R6 disabled changes leave no status
    rd(8'h13, rv); check("R6 status", rv, 8'h00);
    check("R6 irq_n", {7'b0, irq_n}, 8'h01);

    // R4
    wr(8'h12, 8'hFF); rd(8'h12, rv); check("R4 enable rd", rv, 8'h20);
    check("R6 enable later irq_n", {7'b0, irq_n}, 8'h01);

    // R5 declare
    send_frames(63, 1);
    check("R5 declare irq_n", {7'b0, irq_n}, 8'h00);
    // R9 write ignored
    wr(8'h10, 8'h00); rd(8'h10, rv); check("R9 state", rv, 8'h80);
    // R7
    rd(8'h13, rv); check("R7 read value", rv, 8'h20);
    check("R7 irq_n", {7'b0, irq_n}, 8'h01);
    rd(8'h13, rv); check("R7 cleared", rv, 8'h00);
    // R5 clear
    send_frames(63, 0);
    check("R5 clear irq_n", {7'b0, irq_n}, 8'h00);
    rd(8'h13, rv); check("R5 clear status", rv, 8'h20);

    // R8 collision
    send_frames(62, 1);
    check("R8 pre irq_n", {7'b0, irq_n}, 8'h01);
    @(negedge clk); frame_end = 1; frame_ais = 1; cpu_addr = 8'h13; cpu_rd = 1;
    #1 rv = cpu_rdata;
    @(negedge clk); frame_end = 0; cpu_rd = 0;
    check("R8 read old", rv, 8'h00);
    check("R8 irq_n", {7'b0, irq_n}, 8'h00);
    rd(8'h13, rv); check("R8 kept", rv, 8'h20);

    // R6 disabled clear
    wr(8'h12, 8'h00);
    send_frames(63, 0);
    rd(8'h10, rv); check("R6 state cleared", rv, 8'h00);
    wr(8'h12, 8'h20);
    check("R6 irq_n", {7'b0, irq_n}, 8'h01);
    rd(8'h13, rv); check("R6 status", rv, 8'h00);

    // R10 reset mid-state
    send_frames(63, 1);
    check("R10 pre irq_n", {7'b0, irq_n}, 8'h00);
    do_reset();
    check("R10 irq_n after", {7'b0, irq_n}, 8'h01);
    rd(8'h10, rv); check("R10 state after", rv, 8'h00);
    rd(8'h12, rv); check("R10 enable after", rv, 8'h00);
    rd(8'h13, rv); check("R10 status after", rv, 8'h00);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule